// File: doc/BRIEF.md
# Low-Power Pad and Clock Gating Controller

This block sits between a chip's functional logic and its output pads and clock enables. It takes a 3-bit power-state code covering processor idle levels (C0, C1, C2) and system sleep levels (S1, S3, S4, S5). It then overrides each output signal's drive value and output enable according to that signal's electrical class. Lines with pull-ups are released rather than pulled low. Lines into a plane that is switched off are either grounded or floated. Bus lines are parked at a fixed value instead of floating. In the same way it gates two groups of clock enables, and it produces an active-low indication of the deep sleep states.

The class of each signal is taken from a configuration vector on the first clock edge after reset is released. A state change is registered on input. The change is then applied in a three-step sequence. When going deeper, drive values change first, output enables one cycle later, and clocks last. When coming back, the order is reversed. A request that arrives while a sequence is running is taken up only after that sequence has finished.

Top module: `lp_gate_ctrl`

## Requirements
- R1: The state input is sampled into a register on every clock edge. Codes are 0=C0, 1=C1, 2=C2, 3=S1, 4=S3, 5=S4, 6=S5. Code 7 behaves exactly as C0: all signals functional and all clocks enabled.
- R2: A signal of class 0 (pull-up) has its output enable forced to 0 whenever the enable stage is in C2, S1, S3, S4 or S5.
- R3: A class 0 signal is never driven low while either the drive stage or the enable stage is low-power (C2 or deeper). Its drive value is forced to 1 in those states.
- R4: A signal of class 1 (off-plane, grounded) drives 0 with its output enable at 1 in S3, S4 and S5.
- R5: A signal of class 2 (off-plane, floated) first has its drive value forced to 0, then has its output enable forced to 0 in S3, S4 and S5.
- R6: A signal of class 3 (bus park) drives its bit of the PARK_VAL parameter with its output enable at 1 in C2, S1, S3, S4 and S5.
- R7: All core clock enables and the active-low sleep indication are 0 when the clock stage is S3, S4 or S5, and 1 otherwise.
- R8: The PCI clock enable is 1 in C0, C1, C2 and S1, and 0 in S3, S4 and S5.
- R9: A deeper request sampled at edge k updates the drive stage at edge k+1, the enable stage at k+2 and the clock stage at k+3.
- R10: A shallower request updates the clock stage first, then the enable stage, then the drive stage, on the same three edges.
- R11: The 2-bit class of signal i sits at bits [2i+1:2i] of the configuration input. It is captured on the first edge after reset release, and later changes to that input have no effect.
- R12: Requests that change during a running sequence are held off. After the sequence ends, the most recently sampled request is applied.
- R13: During reset all stages are C0. Outputs follow the functional inputs and all clock enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstate_i | input | 3 | Requested power-state code |
| cfg_class_i | input | 2*N_SIG | Per-signal class, 2 bits each |
| func_do_i | input | N_SIG | Functional drive values |
| func_oe_i | input | N_SIG | Functional output enables |
| pad_do_o | output | N_SIG | Gated drive values |
| pad_oe_o | output | N_SIG | Gated output enables |
| core_clk_en_o | output | N_CORE_CLK | Core clock group enables |
| pci_clk_en_o | output | 1 | PCI clock enable |
| slp_s3_n_o | output | 1 | Active-low deep-sleep indication |

## Verification
Two functions can act on the same output in one cycle: the staged drive override and the staged enable override. During a transition the two stages hold different states, so a class 0 line could show an enable still on together with a drive already changed. The bench provokes this by stepping through every state in both directions while the functional inputs toggle pseudo-randomly. A reference model built on an event queue predicts every pad and clock bit on every cycle, and a separate per-cycle check confirms that no pull-up line is ever driven low.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [2:0] {
    PS_C0  = 3'd0,
    PS_C1  = 3'd1,
    PS_C2  = 3'd2,
    PS_S1  = 3'd3,
    PS_S3  = 3'd4,
    PS_S4  = 3'd5,
    PS_S5  = 3'd6,
    PS_BAD = 3'd7
  } pstate_e;

  typedef enum logic [1:0] {
    CL_PULLUP  = 2'd0,
    CL_OFF_LOW = 2'd1,
    CL_OFF_TRI = 2'd2,
    CL_PARK    = 2'd3
  } sigclass_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MID  = 2'd1,
    PH_LAST = 2'd2
  } phase_e;

  function automatic pstate_e norm_state(input logic [2:0] code);
    return (code == PS_BAD) ? PS_C0 : pstate_e'(code);
  endfunction

  function automatic logic is_lp(input pstate_e s);
    return (s >= PS_C2) && (s != PS_BAD);
  endfunction

  function automatic logic is_off(input pstate_e s);
    return (s >= PS_S3) && (s != PS_BAD);
  endfunction

endpackage

// File: rtl/lpg_seq.sv
module lpg_seq
  import lpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pstate_i,
  output pstate_e    drv_st_o,
  output pstate_e    oe_st_o,
  output pstate_e    clk_st_o
);

  pstate_e req_q, req_d;
  pstate_e drv_q, drv_d;
  pstate_e oe_q, oe_d;
  pstate_e clk_q, clk_d;
  pstate_e pend_q, pend_d;
  phase_e  ph_q, ph_d;
  logic    deep_q, deep_d;

  always_comb begin
    req_d  = norm_state(pstate_i);
    drv_d  = drv_q;
    oe_d   = oe_q;
    clk_d  = clk_q;
    pend_d = pend_q;
    deep_d = deep_q;
    ph_d   = ph_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_q != oe_q) begin
          pend_d = req_q;
          deep_d = (req_q > oe_q);
          if (req_q > oe_q) drv_d = req_q;
          else              clk_d = req_q;
          ph_d = PH_MID;
        end
      end
      PH_MID: begin
        oe_d = pend_q;
        ph_d = PH_LAST;
      end
      PH_LAST: begin
        if (deep_q) clk_d = pend_q;
        else        drv_d = pend_q;
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= PS_C0;
      drv_q  <= PS_C0;
      oe_q   <= PS_C0;
      clk_q  <= PS_C0;
      pend_q <= PS_C0;
      deep_q <= 1'b0;
      ph_q   <= PH_IDLE;
    end else begin
      req_q  <= req_d;
      drv_q  <= drv_d;
      oe_q   <= oe_d;
      clk_q  <= clk_d;
      pend_q <= pend_d;
      deep_q <= deep_d;
      ph_q   <= ph_d;
    end
  end

  assign drv_st_o = drv_q;
  assign oe_st_o  = oe_q;
  assign clk_st_o = clk_q;

  // R9
  entry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q > $past(oe_q)) |-> ((drv_q == oe_q) && (clk_q == $past(oe_q))));

  // R10
  exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q < $past(oe_q)) |-> ((clk_q == oe_q) && (drv_q == $past(oe_q))));

  // R12
  idle_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> ((drv_q == oe_q) && (oe_q == clk_q)));

endmodule

// File: rtl/lpg_cfg.sv
module lpg_cfg #(
  parameter int N_SIG = 8,
  localparam int CW = 2 * N_SIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_i,
  output logic [CW-1:0] cls_o
);

  logic [CW-1:0] cls_q, cls_d;
  logic          taken_q, taken_d;

  always_comb begin
    cls_d   = cls_q;
    taken_d = 1'b1;
    if (!taken_q) cls_d = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      cls_q   <= cls_d;
      taken_q <= taken_d;
    end
  end

  assign cls_o = cls_q;

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(taken_q) |-> $stable(cls_q));

endmodule

// File: rtl/lpg_pad.sv
module lpg_pad
  import lpg_pkg::*;
#(
  parameter int               N_SIG    = 8,
  parameter logic [N_SIG-1:0] PARK_VAL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*N_SIG-1:0] cls_i,
  input  pstate_e            drv_st_i,
  input  pstate_e            oe_st_i,
  input  logic [N_SIG-1:0]   func_do_i,
  input  logic [N_SIG-1:0]   func_oe_i,
  output logic [N_SIG-1:0]   pad_do_o,
  output logic [N_SIG-1:0]   pad_oe_o
);

  logic drv_lp, drv_off, oe_lp, oe_off;

  assign drv_lp  = is_lp(drv_st_i);
  assign drv_off = is_off(drv_st_i);
  assign oe_lp   = is_lp(oe_st_i);
  assign oe_off  = is_off(oe_st_i);

  for (genvar i = 0; i < N_SIG; i++) begin : g_sig
    sigclass_e cls;
    logic      d_val;
    logic      o_val;

    assign cls = sigclass_e'(cls_i[2*i +: 2]);

    always_comb begin
      d_val = func_do_i[i];
      o_val = func_oe_i[i];
      unique case (cls)
        CL_PULLUP: begin
          if (drv_lp) d_val = 1'b1;
          if (oe_lp)  o_val = 1'b0;
        end
        CL_OFF_LOW: begin
          if (drv_off) d_val = 1'b0;
          if (oe_off)  o_val = 1'b1;
        end
        CL_OFF_TRI: begin
          if (drv_off) d_val = 1'b0;
          if (oe_off)  o_val = 1'b0;
        end
        CL_PARK: begin
          if (drv_lp) d_val = PARK_VAL[i];
          if (oe_lp)  o_val = 1'b1;
        end
        default: ;
      endcase
    end

    assign pad_do_o[i] = d_val;
    assign pad_oe_o[i] = o_val;

    // R3
    pu_never_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cls == CL_PULLUP) && (drv_lp || oe_lp)) |-> !(pad_oe_o[i] && !pad_do_o[i]));

    // R2
    pu_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cls == CL_PULLUP) && oe_lp) |-> !pad_oe_o[i]);

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cls == CL_PARK) && oe_lp && drv_lp) |-> (pad_oe_o[i] && (pad_do_o[i] == PARK_VAL[i])));
  end

endmodule

// File: rtl/lpg_clk.sv
module lpg_clk
  import lpg_pkg::*;
#(
  parameter int N_CORE_CLK = 4
) (
  input  pstate_e               clk_st_i,
  output logic [N_CORE_CLK-1:0] core_en_o,
  output logic                  pci_en_o,
  output logic                  slp_n_o
);

  logic sleep_deep;
  logic pci_run;

  assign sleep_deep = is_off(clk_st_i);
  assign slp_n_o    = !sleep_deep;

  for (genvar k = 0; k < N_CORE_CLK; k++) begin : g_core
    assign core_en_o[k] = slp_n_o;
  end

  always_comb begin
    unique case (clk_st_i)
      PS_C0, PS_C1, PS_C2, PS_S1, PS_BAD: pci_run = 1'b1;
      default:                            pci_run = 1'b0;
    endcase
  end

  assign pci_en_o = pci_run;

endmodule

// File: rtl/lp_gate_ctrl.sv
module lp_gate_ctrl
  import lpg_pkg::*;
#(
  parameter int               N_SIG      = 8,
  parameter int               N_CORE_CLK = 4,
  parameter logic [N_SIG-1:0] PARK_VAL   = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            pstate_i,
  input  logic [2*N_SIG-1:0]    cfg_class_i,
  input  logic [N_SIG-1:0]      func_do_i,
  input  logic [N_SIG-1:0]      func_oe_i,
  output logic [N_SIG-1:0]      pad_do_o,
  output logic [N_SIG-1:0]      pad_oe_o,
  output logic [N_CORE_CLK-1:0] core_clk_en_o,
  output logic                  pci_clk_en_o,
  output logic                  slp_s3_n_o
);

  pstate_e            drv_st, oe_st, clk_st;
  logic [2*N_SIG-1:0] cls;

  lpg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pstate_i (pstate_i),
    .drv_st_o (drv_st),
    .oe_st_o  (oe_st),
    .clk_st_o (clk_st)
  );

  lpg_cfg #(.N_SIG(N_SIG)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_i (cfg_class_i),
    .cls_o (cls)
  );

  lpg_pad #(.N_SIG(N_SIG), .PARK_VAL(PARK_VAL)) u_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls_i     (cls),
    .drv_st_i  (drv_st),
    .oe_st_i   (oe_st),
    .func_do_i (func_do_i),
    .func_oe_i (func_oe_i),
    .pad_do_o  (pad_do_o),
    .pad_oe_o  (pad_oe_o)
  );

  lpg_clk #(.N_CORE_CLK(N_CORE_CLK)) u_clk (
    .clk_st_i  (clk_st),
    .core_en_o (core_clk_en_o),
    .pci_en_o  (pci_clk_en_o),
    .slp_n_o   (slp_s3_n_o)
  );

  // R7
  clk_after_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s3_n_o |-> is_off(oe_st));

  // R8
  pci_follows_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_clk_en_o |-> (core_clk_en_o[0] && slp_s3_n_o));

endmodule

// File: tb/tb_lp_gate_ctrl.sv
`timescale 1ns/1ps
module tb_lp_gate_ctrl;

  localparam int N = 8;
  localparam int NCK = 4;
  localparam logic [N-1:0] PARK = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] pstate;
  logic [2*N-1:0] cfg;
  logic [N-1:0] fdo, foe;
  logic [N-1:0] pdo, poe;
  logic [NCK-1:0] cen;
  logic pci, slpn;

  int errors = 0;
  int checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lp_gate_ctrl #(.N_SIG(N), .N_CORE_CLK(NCK), .PARK_VAL(PARK)) dut (
    .clk(clk), .rst_n(rst_n), .pstate_i(pstate), .cfg_class_i(cfg),
    .func_do_i(fdo), .func_oe_i(foe), .pad_do_o(pdo), .pad_oe_o(poe),
    .core_clk_en_o(cen), .pci_clk_en_o(pci), .slp_s3_n_o(slpn)
  );

  // reference model: event queue of stage updates
  int m_req, m_drv, m_oe, m_clk, m_deep, m_taken;
  logic [2*N-1:0] m_cls;
  int q_st[$];
  int q_v[$];

  function automatic bit lp(int s);  return s >= 2; endfunction
  function automatic bit off(int s); return s >= 4; endfunction

  task automatic apply_ev();
    int st, v;
    st = q_st.pop_front();
    v  = q_v.pop_front();
    if (st == 0) m_drv = v;
    else if (st == 1) m_oe = v;
    else m_clk = v;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_drv = 0; m_oe = 0; m_clk = 0; m_deep = 0; m_taken = 0;
      m_cls = '0; q_st.delete(); q_v.delete();
    end else begin
      if (q_st.size() > 0) apply_ev();
      else if (m_req != m_oe) begin
        m_deep = (m_req > m_oe);
        if (m_deep != 0) begin
          q_st.push_back(0); q_st.push_back(1); q_st.push_back(2);
        end else begin
          q_st.push_back(2); q_st.push_back(1); q_st.push_back(0);
        end
        repeat (3) q_v.push_back(m_req);
        apply_ev();
      end
      if (m_taken == 0) begin m_cls = cfg; m_taken = 1; end
      m_req = (pstate == 3'd7) ? 0 : int'(pstate);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [N-1:0] edo, eoe;
    string tag;
    bit pu_ok;
    pu_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      int c;
      c = int'(m_cls[2*i +: 2]);
      edo[i] = fdo[i]; eoe[i] = foe[i];
      case (c)
        0: begin if (lp(m_drv)) edo[i] = 1'b1; if (lp(m_oe)) eoe[i] = 1'b0; end
        1: begin if (off(m_drv)) edo[i] = 1'b0; if (off(m_oe)) eoe[i] = 1'b1; end
        2: begin if (off(m_drv)) edo[i] = 1'b0; if (off(m_oe)) eoe[i] = 1'b0; end
        default: begin if (lp(m_drv)) edo[i] = PARK[i]; if (lp(m_oe)) eoe[i] = 1'b1; end
      endcase
      if (c == 0 && (lp(m_drv) || lp(m_oe)) && poe[i] && !pdo[i]) pu_ok = 1'b0;
    end
    if (m_drv != m_oe || m_oe != m_clk) tag = (m_deep != 0) ? "R9" : "R10";
    else tag = "R2/R4/R5/R6";
    chk(pdo == edo, {tag, " drive"}, int'(pdo), int'(edo));
    chk(poe == eoe, {tag, " enable"}, int'(poe), int'(eoe));
    chk(cen == (off(m_clk) ? '0 : '1), "R7 core clocks", int'(cen), off(m_clk) ? 0 : 15);
    chk(slpn == !off(m_clk), "R7 sleep indication", int'(slpn), int'(!off(m_clk)));
    chk(pci == !off(m_clk), "R8 pci clock", int'(pci), int'(!off(m_clk)));
    chk(pu_ok, "R3 pull-up low", int'(pdo), int'(edo));
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fdo = lfsr[7:0];
      foe = lfsr[15:8];
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pstate = 3'd0; cfg = 16'hE4E4; fdo = 8'h3C; foe = 8'hF0;
    @(negedge clk);
    // R13 reset state
    chk(cen == '1 && pci && slpn, "R13 clocks in reset", {cen, pci, slpn}, 63);
    chk(poe == foe && pdo == fdo, "R13 pads in reset", int'(poe), int'(foe));
    rst_n = 1'b1;
    tick(2);
    cfg = 16'h1B1B;                       // R11: must be ignored
    tick(2);

    // R9 entry order from settled C0 to S3
    pstate = 3'd4;
    tick(3);
    chk(pci == 1'b1, "R9 clock still on after enable stage", int'(pci), 1);
    chk(poe[2] == 1'b0, "R9 floated line off before clocks", int'(poe[2]), 0);
    tick(1);
    chk(pci == 1'b0, "R9 clock gated last", int'(pci), 0);
    tick(2);
    chk(poe[0] == 1'b0, "R11 class kept from reset capture", int'(poe[0]), 0);

    // R10 exit order back to C0
    pstate = 3'd0;
    tick(2);
    chk(pci == 1'b1, "R10 clock restored first", int'(pci), 1);
    chk(poe[2] == 1'b0, "R10 enable still off", int'(poe[2]), 0);
    tick(4);

    // walk all states deeper then shallower
    for (int s = 1; s <= 6; s++) begin pstate = 3'(s); tick(6); end
    for (int s = 5; s >= 0; s--) begin pstate = 3'(s); tick(6); end

    // R1 unrecognised code from S5
    pstate = 3'd6; tick(6);
    pstate = 3'd7; tick(6);
    chk(pci && slpn && cen == '1, "R1 code 7 as C0", {cen, pci, slpn}, 63);

    // R12 requests changing mid-sequence
    pstate = 3'd4; tick(2);
    pstate = 3'd1; tick(1);
    pstate = 3'd2; tick(12);
    chk(pci == 1'b1 && poe[0] == 1'b0, "R12 last request applied", {pci, poe[0]}, 2);

    // second reset with the other class pattern
    @(negedge clk);
    rst_n = 1'b0; cfg = 16'h1B1B; pstate = 3'd0;
    @(negedge clk);
    chk(cen == '1 && pci && slpn, "R13 clocks in second reset", {cen, pci, slpn}, 63);
    rst_n = 1'b1;
    tick(3);
    for (int s = 2; s <= 6; s += 2) begin pstate = 3'(s); tick(7); end
    pstate = 3'd3; tick(7);
    pstate = 3'd0; tick(7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule